// File: doc/BRIEF.md
# Sequential Channel Arbiter and Power-Mode Controller

This block sequences a three-channel light-source driver through its power modes and decides which single channel may conduct at any moment. A chip enable moves it out of shutdown. A short startup phase then asks for the stored configuration to be copied into the registers. After that the block rests in standby until a channel is requested. A ramp phase with a selectable length follows, and then normal operation. If every request stays low for a selectable idle period, the block drops back to standby.

Channel grants never preempt each other. A request that rises while another channel conducts waits until that channel's request falls. When the grant is released and several requests are waiting, red wins over green, and green wins over blue. Thermal and supply faults push the block into standby and keep it there. All long intervals are counted on a prescaled tick input, so the same logic serves real and shortened time bases.

Top module: `seq_light_ctrl`

## Requirements
- R1: While rst_n is low the mode is shutdown. One clock edge after chip_en is sampled low, the mode is shutdown with ch_on, conv_en and cfg_load all low. Mode codes are 0 shutdown, 1 startup, 2 standby, 3 ramp (soft-start) and 4 normal.
- R2: With chip_en high, shutdown moves to startup on the next edge. The block stays in startup for STARTUP_CYC clock cycles with cfg_load high, then enters standby.
- R3: nvm_wr_ok is high only in standby, and conv_en is low in standby.
- R4: In standby, with no fault, any request bit moves the block to the ramp mode on the next edge. ss_sel sets the ramp length: 0 skips the ramp and goes straight to normal, 1 gives TICKS_HALF ticks, 2 gives 2×TICKS_HALF ticks and 3 gives 4×TICKS_HALF ticks. Only cycles with tick high count.
- R5: In normal mode, once all request bits have been low for TICKS_Q<<idle_sel consecutive ticks, the block returns to standby. Any high request restarts this count.
- R6: A high thermal_trip or undervolt forces standby from ramp or normal on the next edge. The block stays in standby while the fault is present.
- R7: ch_on is at most one-hot and is zero outside normal mode. conv_en is high in the ramp and normal modes only.
- R8: A channel that holds the grant keeps it for as long as its own request stays high, whatever other requests do.
- R9: When no channel holds a live grant in normal mode, the grant goes to the lowest requested bit. Bit 0 is red, bit 1 is green and bit 2 is blue, so the priority is red, then green, then blue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| chip_en | input | 1 | Chip enable |
| ch_req | input | 3 | Channel requests: bit0 red, bit1 green, bit2 blue |
| thermal_trip | input | 1 | Over-temperature flag |
| undervolt | input | 1 | Supply undervoltage flag |
| ss_sel | input | 2 | Ramp length select |
| idle_sel | input | 2 | Idle timeout select |
| tick | input | 1 | Prescaled time-base strobe |
| mode | output | 3 | Current mode code |
| ch_on | output | 3 | One-hot active channel |
| cfg_load | output | 1 | Request to copy stored configuration into the registers |
| conv_en | output | 1 | Converter enable |
| nvm_wr_ok | output | 1 | Non-volatile writes permitted |

## Verification
The grant-hold and priority properties are only checked while chip_en is high and both fault flags are low, because a fault or a disable legitimately clears the grant. The properties also assume that ss_sel and idle_sel are held steady during a ramp or an idle wait. The stimulus changes those fields only in standby or while a request is high, and it raises faults only with chip_en high. Inputs change half a cycle away from the sampling edge, so every request pattern in the arbitration table is seen for whole cycles.

// File: rtl/seq_light_ctrl.sv
module seq_light_ctrl #(
  parameter int TICKS_HALF  = 500,
  parameter int TICKS_Q     = 125,
  parameter int STARTUP_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chip_en,
  input  logic [2:0] ch_req,
  input  logic       thermal_trip,
  input  logic       undervolt,
  input  logic [1:0] ss_sel,
  input  logic [1:0] idle_sel,
  input  logic       tick,
  output logic [2:0] mode,
  output logic [2:0] ch_on,
  output logic       cfg_load,
  output logic       conv_en,
  output logic       nvm_wr_ok
);
  localparam logic [2:0] M_OFF  = 3'd0;
  localparam logic [2:0] M_BOOT = 3'd1;
  localparam logic [2:0] M_IDLE = 3'd2;
  localparam logic [2:0] M_SOFT = 3'd3;
  localparam logic [2:0] M_RUN  = 3'd4;

  localparam int SS_MAX  = TICKS_HALF * 4;
  localparam int ID_MAX  = TICKS_Q * 8;
  localparam int T_MAX   = (SS_MAX > ID_MAX) ? SS_MAX : ID_MAX;
  localparam int ALL_MAX = (T_MAX > STARTUP_CYC) ? T_MAX : STARTUP_CYC;
  localparam int CNT_W   = $clog2(ALL_MAX + 1);

  logic [CNT_W-1:0] cnt, cnt_nx, ss_lim, idle_lim;
  logic [2:0] mode_nx, grant_nx;
  logic fault, any_req;

  assign fault   = thermal_trip | undervolt;
  assign any_req = |ch_req;

  always_comb begin
    case (ss_sel)
      2'd1:    ss_lim = CNT_W'(TICKS_HALF);
      2'd2:    ss_lim = CNT_W'(TICKS_HALF * 2);
      default: ss_lim = CNT_W'(TICKS_HALF * 4);
    endcase
    case (idle_sel)
      2'd0:    idle_lim = CNT_W'(TICKS_Q);
      2'd1:    idle_lim = CNT_W'(TICKS_Q * 2);
      2'd2:    idle_lim = CNT_W'(TICKS_Q * 4);
      default: idle_lim = CNT_W'(TICKS_Q * 8);
    endcase
  end

  always_comb begin
    mode_nx = mode;
    cnt_nx  = cnt;
    case (mode)
      M_OFF:
        if (chip_en) begin
          mode_nx = M_BOOT;
          cnt_nx  = '0;
        end
      M_BOOT:
        if (cnt == CNT_W'(STARTUP_CYC - 1)) begin
          mode_nx = M_IDLE;
          cnt_nx  = '0;
        end else begin
          cnt_nx = cnt + 1'b1;
        end
      M_IDLE:
        if (!fault && any_req) begin
          mode_nx = (ss_sel == 2'd0) ? M_RUN : M_SOFT;
          cnt_nx  = '0;
        end
      M_SOFT:
        if (fault) begin
          mode_nx = M_IDLE;
        end else if (tick) begin
          if (cnt == ss_lim - 1'b1) begin
            mode_nx = M_RUN;
            cnt_nx  = '0;
          end else begin
            cnt_nx = cnt + 1'b1;
          end
        end
      M_RUN:
        if (fault) begin
          mode_nx = M_IDLE;
        end else if (any_req) begin
          cnt_nx = '0;
        end else if (tick) begin
          if (cnt == idle_lim - 1'b1) begin
            mode_nx = M_IDLE;
            cnt_nx  = '0;
          end else begin
            cnt_nx = cnt + 1'b1;
          end
        end
      default: mode_nx = M_OFF;
    endcase
    if (!chip_en) begin
      mode_nx = M_OFF;
      cnt_nx  = '0;
    end
  end

  always_comb begin
    grant_nx = '0;
    if (mode_nx == M_RUN) begin
      if (|(ch_on & ch_req)) grant_nx = ch_on;
      else if (ch_req[0])    grant_nx = 3'b001;
      else if (ch_req[1])    grant_nx = 3'b010;
      else if (ch_req[2])    grant_nx = 3'b100;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= M_OFF;
      cnt   <= '0;
      ch_on <= '0;
    end else begin
      mode  <= mode_nx;
      cnt   <= cnt_nx;
      ch_on <= grant_nx;
    end
  end

  assign cfg_load  = (mode == M_BOOT);
  assign conv_en   = (mode == M_SOFT) || (mode == M_RUN);
  assign nvm_wr_ok = (mode == M_IDLE);
endmodule

// File: rtl/seq_light_ctrl_chk.sv
module seq_light_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       chip_en,
  input logic [2:0] ch_req,
  input logic       thermal_trip,
  input logic       undervolt,
  input logic [2:0] mode,
  input logic [2:0] ch_on,
  input logic       conv_en
);
  logic calm;
  assign calm = chip_en && !thermal_trip && !undervolt;

  p_off_when_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> (mode == 3'd0 && ch_on == 3'b000 && !conv_en));

  p_boot_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && chip_en) |=> mode == 3'd1);

  p_boot_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && chip_en) |=> (mode == 3'd1 || mode == 3'd2));

  p_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 && calm && ch_req != 3'b000) |=> (mode == 3'd3 || mode == 3'd4));

  p_fault_standby_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && (thermal_trip || undervolt) && mode >= 3'd2 && mode <= 3'd4) |=> mode == 3'd2);

  p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_on));

  p_off_outside_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_on != 3'b000) |-> mode == 3'd4);

  p_hold_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && calm && (ch_on & ch_req) != 3'b000) |=> ch_on == $past(ch_on));

  p_red_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && calm && (ch_on & ch_req) == 3'b000 && ch_req[0]) |=> ch_on == 3'b001);
endmodule

bind seq_light_ctrl seq_light_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .ch_req(ch_req),
  .thermal_trip(thermal_trip), .undervolt(undervolt),
  .mode(mode), .ch_on(ch_on), .conv_en(conv_en)
);

// File: tb/seq_light_ctrl_bench.sv
module seq_light_ctrl_bench;
  logic clk = 0, rst_n = 0, chip_en = 0, thermal_trip = 0, undervolt = 0, tick = 1;
  logic [2:0] ch_req = 0;
  logic [1:0] ss_sel = 0, idle_sel = 0;
  logic [2:0] mode, ch_on;
  logic cfg_load, conv_en, nvm_wr_ok;
  int total = 0, bad = 0, n = 0;
  bit finished = 0;

  seq_light_ctrl #(.TICKS_HALF(4), .TICKS_Q(2), .STARTUP_CYC(3)) u_seq_light_ctrl (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .ch_req(ch_req),
    .thermal_trip(thermal_trip), .undervolt(undervolt), .ss_sel(ss_sel),
    .idle_sel(idle_sel), .tick(tick), .mode(mode), .ch_on(ch_on),
    .cfg_load(cfg_load), .conv_en(conv_en), .nvm_wr_ok(nvm_wr_ok));

  initial forever #5 clk = ~clk;

  // {requests, expected grant}
  localparam logic [5:0] ARB_TAB [12] = '{
    {3'b001, 3'b001}, {3'b011, 3'b001}, {3'b010, 3'b010}, {3'b111, 3'b010},
    {3'b101, 3'b001}, {3'b100, 3'b100}, {3'b110, 3'b100}, {3'b010, 3'b010},
    {3'b011, 3'b010}, {3'b001, 3'b001}, {3'b110, 3'b010}, {3'b100, 3'b100}};

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int k = 1);
    repeat (k) @(negedge clk);
  endtask

  task automatic steps_to(input logic [2:0] target, input int maxn, output int cnt);
    cnt = 0;
    do begin
      step();
      cnt++;
    end while (mode != target && cnt < maxn);
  endtask

  initial begin
    step(2);
    check("R1 reset mode", mode, 0);
    check("R1 reset ch_on", ch_on, 0);
    check("R1 reset conv_en", conv_en, 0);
    rst_n = 1; ch_req = 3'b111;
    step(3);
    check("R1 chip_en low keeps shutdown", mode, 0);
    check("R7 no channel in shutdown", ch_on, 0);

    ch_req = 0; chip_en = 1;
    step();
    check("R2 startup mode", mode, 1);
    check("R2 cfg_load in startup", cfg_load, 1);
    steps_to(3'd2, 20, n);
    check("R2 startup length", n, 3);
    check("R2 cfg_load off", cfg_load, 0);
    check("R3 nvm_wr_ok in standby", nvm_wr_ok, 1);
    check("R3 conv_en off in standby", conv_en, 0);

    ss_sel = 2'd1; ch_req = 3'b001;
    step();
    check("R4 ramp entered", mode, 3);
    check("R7 conv_en in ramp", conv_en, 1);
    check("R7 no channel in ramp", ch_on, 0);
    check("R3 nvm_wr_ok off in ramp", nvm_wr_ok, 0);
    steps_to(3'd4, 40, n);
    check("R4 ramp of 4 ticks", n, 4);
    check("R9 first grant red", ch_on, 1);

    foreach (ARB_TAB[i]) begin
      ch_req = ARB_TAB[i][5:3];
      step();
      check($sformatf("R8/R9 arbitration row %0d", i), ch_on, ARB_TAB[i][2:0]);
    end

    idle_sel = 2'd0; ch_req = 0;
    step();
    check("R5 still normal after one idle tick", mode, 4);
    check("R7 grant released", ch_on, 0);
    steps_to(3'd2, 20, n);
    check("R5 idle timeout of 2 ticks", n, 1);

    ss_sel = 2'd0; ch_req = 3'b010;
    step();
    check("R4 ramp skipped", mode, 4);
    check("R9 green granted", ch_on, 2);
    idle_sel = 2'd1; ch_req = 0;
    step(3);
    check("R5 normal before timeout", mode, 4);
    ch_req = 3'b100;
    step();
    check("R9 blue granted", ch_on, 4);
    ch_req = 0;
    step(3);
    check("R5 request restarted idle count", mode, 4);
    step();
    check("R5 idle timeout of 4 ticks", mode, 2);

    ss_sel = 2'd2; tick = 0; ch_req = 3'b001;
    step();
    check("R4 ramp entered again", mode, 3);
    step(20);
    check("R4 ramp frozen without tick", mode, 3);
    tick = 1;
    steps_to(3'd4, 40, n);
    check("R4 ramp of 8 ticks", n, 8);

    thermal_trip = 1;
    step();
    check("R6 thermal forces standby", mode, 2);
    check("R7 channel off on fault", ch_on, 0);
    step(5);
    check("R6 held in standby during fault", mode, 2);
    thermal_trip = 0; ss_sel = 2'd3;
    step();
    check("R4 ramp after fault clears", mode, 3);
    steps_to(3'd4, 40, n);
    check("R4 ramp of 16 ticks", n, 16);

    undervolt = 1;
    step();
    check("R6 undervolt forces standby", mode, 2);
    undervolt = 0;
    step();
    check("R4 ramp entered after undervolt", mode, 3);
    undervolt = 1;
    step();
    check("R6 undervolt aborts ramp", mode, 2);
    undervolt = 0;
    step();
    chip_en = 0;
    step();
    check("R1 chip_en low from ramp", mode, 0);
    check("R1 conv_en off", conv_en, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule